// File: doc/BRIEF.md
# Bus Cycle Response Monitor

This block guards a bus against cycles that are never answered. A master opens a bus cycle by pulling its strobe low. The monitor then counts system clocks while it waits for the slave to end the cycle. A slave ends the cycle with one of two active-low acknowledges: a data-size acknowledge or an autovector acknowledge. If neither arrives within the programmed number of clocks, the monitor pulls an active-low bus error line. The master uses that line to abandon the cycle. The bus error is held until the master lets go of its strobe.

A 2-bit select picks the timeout. Larger select values give shorter windows, so the window halves with each step. An enable input switches the whole monitor off. The two acknowledges may come from slaves on other clocks, so each one passes through its own two-stage synchronizer before the timing logic uses it. The strobe, the select and the enable are taken to be synchronous to the monitor clock.

Top module: `bmon_top`

## Requirements
- R1: Timing starts at the first rising edge that samples `cyc_strb_n` low; that edge is count 1. The count goes back to zero whenever a rising edge samples `cyc_strb_n` high, so every bus cycle is timed from its own start.
- R2: With no acknowledge, `berr_n` goes low right after rising edge L+1 of the cycle, where L is the selected limit and edge 1 is the first edge that samples the strobe low.
- R3: `tmo_sel` sets L as follows: 2'b00 gives 64, 2'b01 gives 32, 2'b10 gives 16, 2'b11 gives 8 (defaults, with `LIM_SHORT` = 8 and L = `LIM_SHORT` shifted left by the inverted select).
- R4: `dack_n` and `avack_n` each pass through two flops before they are used. An acknowledge first sampled low at edge L-1 or earlier prevents the bus error. One first sampled low at edge L or later does not.
- R5: The autovector acknowledge `avack_n` ends a cycle exactly as the data-size acknowledge `dack_n` does, with the same timing.
- R6: Once low, `berr_n` stays low while `cyc_strb_n` stays low and `mon_en` stays high. It returns high right after the first rising edge that samples `cyc_strb_n` high.
- R7: A rising edge that samples `mon_en` low leaves `berr_n` high after that edge, including when it was low. No timeout is raised in a bus cycle during which `mon_en` was sampled low.
- R8: `tmo_sel` is captured at the first edge of a bus cycle. Changing it later in the same cycle has no effect on that cycle's limit.
- R9: While `rst_n` is low, `berr_n` is high and the monitor is idle.
- R10: Once an acknowledge has been seen in a cycle, no bus error is raised for the rest of that cycle, even if the acknowledge goes high again while the strobe stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mon_en | input | 1 | Monitor enable; when low no timeout is raised |
| tmo_sel | input | 2 | Timeout select; larger values give shorter limits |
| cyc_strb_n | input | 1 | Bus cycle strobe from the master, active low |
| dack_n | input | 1 | Data-size acknowledge, active low, asynchronous |
| avack_n | input | 1 | Autovector acknowledge, active low, asynchronous |
| berr_n | output | 1 | Bus error, active low, registered |

## Verification
Count the edges of a cycle from edge 1, the first edge that samples the strobe low. The bus error is due right after edge L+1. It releases right after the first edge that samples the strobe high. An acknowledge counts only if the first synchronizer flop captures it by edge L-1, because it needs two synchronizer stages and then the state register before it can take effect. The bench drives every input at the falling edge and numbers the strobe-low edges itself. It samples 2 ns after each rising edge and compares the edge at which the bus error fell, and the release at the end of the cycle, against an expected item queued by the driver. The edge-L-1 and edge-L acknowledge cases are run for both the shortest and the longest limit.

// File: rtl/bmon_pkg.sv
package bmon_pkg;

    // Phase of the bus cycle being watched
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,   // no cycle open
        ST_RUN   = 2'd1,   // cycle open, counting clocks
        ST_DONE  = 2'd2,   // cycle answered or not timed, waiting for strobe release
        ST_FAULT = 2'd3    // timed out, bus error driven
    } bmon_state_e;

    // Number of timeout select codes, and the shift applied to the shortest limit
    localparam int unsigned SEL_W     = 2;
    localparam int unsigned SEL_CODES = 1 << SEL_W;

endpackage

// File: rtl/bmon_sync.sv
// Multi-stage synchronizer for a vector of asynchronous inputs.
module bmon_sync #(
    parameter int unsigned WIDTH   = 2,
    parameter int unsigned STAGES  = 2,    // at least 2
    parameter logic        RST_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    localparam int unsigned TOT_W = WIDTH * STAGES;

    logic [STAGES-1:0][WIDTH-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= {TOT_W{RST_VAL}};
        end else begin
            sh_q <= sh_d;
        end
    end

    assign q = sh_q[STAGES-1];

endmodule

// File: rtl/bmon_limit.sv
// Turns the timeout select code into a clock count. Larger codes give
// shorter limits; each step halves the window.
module bmon_limit
    import bmon_pkg::*;
#(
    parameter int unsigned LIM_SHORT = 8,
    parameter int unsigned CNT_W     = 7
) (
    input  logic [SEL_W-1:0] code,
    output logic [CNT_W-1:0] lim
);

    logic [SEL_W-1:0] shift_amt;
    logic [CNT_W-1:0] base;

    always_comb begin
        shift_amt = ~code;
        base      = CNT_W'(LIM_SHORT);
        lim       = base << shift_amt;
    end

endmodule

// File: rtl/bmon_ctrl.sv
// Cycle state machine and clock counter. All next values are formed in one
// struct and registered together.
module bmon_ctrl
    import bmon_pkg::*;
#(
    parameter int unsigned CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             strb_n,
    input  logic             ack_seen,
    input  logic [CNT_W-1:0] lim_in,
    output logic             berr_n
);

    typedef struct packed {
        bmon_state_e      st;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] lim;
        logic             berr_n;
    } ctrl_t;

    ctrl_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (!en) begin
            // Disabled: no timing; a cycle in progress is left untimed
            nxt_d.st     = strb_n ? ST_IDLE : ST_DONE;
            nxt_d.cnt    = '0;
            nxt_d.berr_n = 1'b1;
        end else begin
            case (cur_q.st)
                ST_IDLE: begin
                    if (!strb_n) begin
                        nxt_d.st  = ST_RUN;
                        nxt_d.cnt = CNT_W'(1);
                        nxt_d.lim = lim_in;
                    end
                end
                ST_RUN: begin
                    if (strb_n) begin
                        nxt_d.st  = ST_IDLE;
                        nxt_d.cnt = '0;
                    end else if (ack_seen) begin
                        nxt_d.st  = ST_DONE;
                        nxt_d.cnt = '0;
                    end else if (cur_q.cnt == cur_q.lim) begin
                        nxt_d.st     = ST_FAULT;
                        nxt_d.berr_n = 1'b0;
                    end else begin
                        nxt_d.cnt = cur_q.cnt + CNT_W'(1);
                    end
                end
                ST_DONE: begin
                    if (strb_n) begin
                        nxt_d.st = ST_IDLE;
                    end
                end
                ST_FAULT: begin
                    if (strb_n) begin
                        nxt_d.st     = ST_IDLE;
                        nxt_d.cnt    = '0;
                        nxt_d.berr_n = 1'b1;
                    end
                end
                default: begin
                    nxt_d.st     = ST_IDLE;
                    nxt_d.cnt    = '0;
                    nxt_d.berr_n = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.st     <= ST_IDLE;
            cur_q.cnt    <= '0;
            cur_q.lim    <= '0;
            cur_q.berr_n <= 1'b1;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign berr_n = cur_q.berr_n;

endmodule

// File: rtl/bmon_top.sv
module bmon_top
    import bmon_pkg::*;
#(
    parameter int unsigned LIM_SHORT   = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mon_en,
    input  logic [1:0] tmo_sel,
    input  logic       cyc_strb_n,
    input  logic       dack_n,
    input  logic       avack_n,
    output logic       berr_n
);

    localparam int unsigned LIM_LONG = LIM_SHORT << (SEL_CODES - 1);
    localparam int unsigned CNT_W    = $clog2(LIM_LONG + 1);
    localparam int unsigned N_ACK    = 2;

    logic [N_ACK-1:0] ack_raw, ack_sync;
    logic             ack_seen;
    logic [CNT_W-1:0] lim;

    assign ack_raw = {avack_n, dack_n};

    bmon_sync #(
        .WIDTH  (N_ACK),
        .STAGES (SYNC_STAGES),
        .RST_VAL(1'b1)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (ack_raw),
        .q    (ack_sync)
    );

    // Either acknowledge low ends the cycle
    assign ack_seen = ~(&ack_sync);

    bmon_limit #(
        .LIM_SHORT(LIM_SHORT),
        .CNT_W    (CNT_W)
    ) u_limit (
        .code(tmo_sel),
        .lim (lim)
    );

    bmon_ctrl #(
        .CNT_W(CNT_W)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (mon_en),
        .strb_n  (cyc_strb_n),
        .ack_seen(ack_seen),
        .lim_in  (lim),
        .berr_n  (berr_n)
    );

endmodule

// File: rtl/bmon_chk.sv
module bmon_chk #(
    parameter int unsigned LIM_SHORT = 8
) (
    input logic clk,
    input logic rst_n,
    input logic mon_en,
    input logic cyc_strb_n,
    input logic berr_n
);

    localparam int unsigned RUN_W = 16;

    // Consecutive edges that sampled the strobe low (saturating)
    logic [RUN_W-1:0] low_run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_run_q <= '0;
        end else if (cyc_strb_n) begin
            low_run_q <= '0;
        end else if (low_run_q != {RUN_W{1'b1}}) begin
            low_run_q <= low_run_q + RUN_W'(1);
        end
    end

    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> berr_n);                                                   // R9

    AST_MIN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(berr_n) |-> (low_run_q >= RUN_W'(LIM_SHORT + 1)));              // R2

    AST_HOLD_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (!berr_n && !cyc_strb_n && mon_en) |=> !berr_n);                      // R6

    AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (!berr_n && cyc_strb_n) |=> berr_n);                                  // R6

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !mon_en |=> berr_n);                                                  // R7

    AST_NO_IDLE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_strb_n && berr_n) |=> berr_n);                                   // R1

endmodule

bind bmon_top bmon_chk #(
    .LIM_SHORT(LIM_SHORT)
) u_bmon_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mon_en    (mon_en),
    .cyc_strb_n(cyc_strb_n),
    .berr_n    (berr_n)
);

// File: tb/tb_bmon_top.sv
`timescale 1ns/1ps
module tb_bmon_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mon_en = 1'b1;
    logic [1:0] tmo_sel = 2'b00;
    logic       cyc_strb_n = 1'b1;
    logic       dack_n = 1'b1;
    logic       avack_n = 1'b1;
    logic       berr_n;

    bmon_top dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .mon_en    (mon_en),
        .tmo_sel   (tmo_sel),
        .cyc_strb_n(cyc_strb_n),
        .dack_n    (dack_n),
        .avack_n   (avack_n),
        .berr_n    (berr_n)
    );

    always #5 clk = ~clk;

    typedef struct {
        bit    fault;
        int    fall;
        string tag;
    } exp_t;

    exp_t sbq[$];
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int lim_of(input logic [1:0] c);
        return 8 << (3 - int'(c));
    endfunction

    // Driver: runs one bus cycle and queues the expected outcome.
    // Edge e is the e-th rising edge that samples the strobe low.
    task automatic bus_cycle(input logic [1:0] code, input logic en_v,
                             input int hold, input int ack_edge,
                             input int ack_len, input bit use_avec,
                             input int sel_edge, input logic [1:0] sel_new,
                             input int en_off_edge, input string tag);
        exp_t it;
        int   lim;
        bit   saved;
        lim   = lim_of(code);
        saved = (ack_edge != 0) && (ack_edge <= lim - 1);
        it.fault = en_v && (hold >= lim + 1) && !saved &&
                   ((en_off_edge == 0) || (en_off_edge > lim + 1));
        it.fall  = lim + 1;
        it.tag   = tag;
        sbq.push_back(it);
        tmo_sel = code;
        mon_en  = en_v;
        cyc_strb_n = 1'b0;
        for (int e = 1; e <= hold; e++) begin
            if (e == ack_edge) begin
                if (use_avec) avack_n = 1'b0; else dack_n = 1'b0;
            end
            if (ack_len > 0 && e == ack_edge + ack_len) begin
                avack_n = 1'b1;
                dack_n  = 1'b1;
            end
            if (e == sel_edge) tmo_sel = sel_new;
            if (e == en_off_edge) mon_en = 1'b0;
            @(negedge clk);
            if (e == en_off_edge)
                chk(berr_n === 1'b1, "R7", "berr_n after enable dropped", int'(berr_n), 1);
        end
        cyc_strb_n = 1'b1;
        dack_n     = 1'b1;
        avack_n    = 1'b1;
        mon_en     = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    // Monitor: numbers strobe-low edges, records the bus error fall, and
    // compares against the queue when the cycle closes.
    int k = 0;
    bit in_cyc = 1'b0;
    bit seen = 1'b0;
    int fall = 0;
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (rst_n) begin
                if (!cyc_strb_n) begin
                    k++;
                    in_cyc = 1'b1;
                    if (!berr_n && !seen) begin
                        seen = 1'b1;
                        fall = k;
                    end
                end else if (in_cyc) begin
                    exp_t it;
                    chk(berr_n === 1'b1, "R6", "berr_n after strobe release", int'(berr_n), 1);
                    if (sbq.size() == 0) begin
                        chk(1'b0, "R1", "unexpected cycle", 0, 1);
                    end else begin
                        it = sbq.pop_front();
                        chk(seen == it.fault, it.tag, "fault raised", int'(seen), int'(it.fault));
                        if (it.fault && seen)
                            chk(fall == it.fall, it.tag, "fall edge", fall, it.fall);
                    end
                    in_cyc = 1'b0;
                    k      = 0;
                    seen   = 1'b0;
                end
            end
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(berr_n === 1'b1, "R9", "berr_n in reset", int'(berr_n), 1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(berr_n === 1'b1, "R9", "berr_n after reset", int'(berr_n), 1);

        // R2 R3: no answer, each limit
        bus_cycle(2'b11, 1, 12, 0, 0, 0, 0, 2'b00, 0, "R3_sel11");
        bus_cycle(2'b10, 1, 20, 0, 0, 0, 0, 2'b00, 0, "R3_sel10");
        bus_cycle(2'b01, 1, 36, 0, 0, 0, 0, 2'b00, 0, "R3_sel01");
        bus_cycle(2'b00, 1, 70, 0, 0, 0, 0, 2'b00, 0, "R2_sel00");
        // R4: acknowledge boundary, shortest and longest limit
        bus_cycle(2'b11, 1, 12, 7, 0, 0, 0, 2'b00, 0, "R4_ack_L-1");
        bus_cycle(2'b11, 1, 12, 8, 0, 0, 0, 2'b00, 0, "R4_ack_L");
        bus_cycle(2'b00, 1, 70, 63, 0, 0, 0, 2'b00, 0, "R4_long_ack_L-1");
        bus_cycle(2'b00, 1, 70, 64, 0, 0, 0, 2'b00, 0, "R4_long_ack_L");
        // R5: autovector acknowledge, same boundary
        bus_cycle(2'b11, 1, 12, 7, 0, 1, 0, 2'b00, 0, "R5_avec_L-1");
        bus_cycle(2'b11, 1, 12, 8, 0, 1, 0, 2'b00, 0, "R5_avec_L");
        bus_cycle(2'b10, 1, 20, 3, 0, 1, 0, 2'b00, 0, "R5_avec_early");
        // R1: a cycle of exactly L edges, then a fresh full cycle
        bus_cycle(2'b11, 1, 8, 0, 0, 0, 0, 2'b00, 0, "R1_short");
        bus_cycle(2'b11, 1, 12, 0, 0, 0, 0, 2'b00, 0, "R1_restart");
        // R8: select changed mid cycle
        bus_cycle(2'b00, 1, 70, 0, 0, 0, 3, 2'b11, 0, "R8_sel_change");
        bus_cycle(2'b11, 1, 12, 0, 0, 0, 2, 2'b00, 0, "R8_sel_change_b");
        // R7: disabled, and disabled while faulted
        bus_cycle(2'b11, 0, 30, 0, 0, 0, 0, 2'b00, 0, "R7_off");
        bus_cycle(2'b11, 1, 20, 0, 0, 0, 0, 2'b00, 12, "R7_off_in_fault");
        bus_cycle(2'b11, 1, 20, 0, 0, 0, 0, 2'b00, 4, "R7_off_early");
        // R10: one-clock acknowledge pulse then long wait
        bus_cycle(2'b11, 1, 20, 2, 1, 0, 0, 2'b00, 0, "R10_pulse");
        bus_cycle(2'b11, 1, 20, 2, 1, 1, 0, 2'b00, 0, "R10_pulse_avec");

        repeat (4) @(negedge clk);
        chk(sbq.size() == 0, "R1", "items left in queue", sbq.size(), 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule